// File: doc/BRIEF.md
# Indexed RTC Control Register File

This block sits between a two-port byte bus and the rest of a real-time clock. A write to the even port loads a 7-bit index. Reads and writes on the odd port reach the byte that index selects, in a 128-byte space. Most bytes are plain storage. Four control bytes behave specially:

- **Rate/divider byte** (index 0x0A): bit 7 is a live update-in-progress status that software cannot write.
- **Control byte** (0x0B): holds the enables and the SET freeze bit.
- **Flag byte** (0x0C): clears itself when it is read.
- **Status byte** (0x0D): fixed.

The block holds the sub-second phase. From it, it drives the run enable and a one-second update strobe for the separate time counters. It also collects the periodic, alarm and update-ended flag pulses from the neighbouring generators and drives the interrupt line.

The phase is governed by a four-state machine. `ST_DIVRST` means the divider is held in reset. `ST_IDLE` means the rate selection is invalid but not in reset. `ST_FROZEN` means the divider is valid but SET is 1. `ST_RUN` means the clock is counting. Each cycle the machine moves to the state that the next register contents select. The transitions are:

- **ST_DIVRST→ST_RUN ("release")**: preloads the phase to half a second.
- **Any state→ST_DIVRST ("divider reset")**: clears the phase.
- **ST_RUN→ST_FROZEN ("freeze")**: holds the phase.
- **ST_FROZEN→ST_RUN ("resume")**: holds the phase, so counting continues from the held value.
- **ST_RUN↔ST_IDLE ("rate invalid", "rate valid")**: holds the phase.
- **ST_DIVRST→ST_FROZEN or ST_DIVRST→ST_IDLE**: leaves the phase at zero.

Top module: `rtc_index_regs`

## Requirements
- R1: A write on the even port (port_sel=0) stores wdata[6:0] as the index; bit 7 is dropped. An odd-port (port_sel=1) write to a plain byte stores it, and odd-port rdata returns the byte at the index.
- R2: Writes to the flag byte (0x0C) and the status byte (0x0D) are ignored. The status byte always reads 0x80.
- R3: A write to byte 0x0A stores only bits 6:0. Bit 7 of the read value is the live update-in-progress status, never the written bit.
- R4: Reading byte 0x0C returns {IRQF, PF, AF, UF, 4'b0} (bits 7, 6, 5, 4), then clears the byte and lowers irq_o. A flag pulse that arrives in the same cycle as the read survives the clear and raises IRQF if it is enabled.
- R5: A pulse on pf_i, af_i or uf_i sets bit 6, 5 or 4 of byte 0x0C. If the matching enable in byte 0x0B (PIE bit 6, AIE bit 5, UIE bit 4) is set and the flag was clear, IRQF and irq_o go high from the next cycle.
- R6: On a write to byte 0x0B, irq_o and IRQF become 1 if any enable in the written data matches a set flag, and 0 otherwise.
- R7: run_en_o is 1 exactly when SET (bit 7 of byte 0x0B) is 0 and bits 6:4 of byte 0x0A are at most 2.
- R8: While running, upd_o pulses once every TICKS ticks of tick_i. The update-in-progress bit reads 1 during the last UIP_W ticks of each second, including the tick of the strobe.
- R9: When bits 6:5 of byte 0x0A are both 1, the phase is cleared, no strobes occur and the update-in-progress bit reads 0. Releasing straight to a valid rate with SET=0 gives the first strobe TICKS/2 ticks later.
- R10: SET=1 stops strobes, reads the update-in-progress bit as 0 and holds the phase. Clearing SET resumes from the held phase.
- R11: After power-on reset, byte 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00 and 0x0D reads 0x80. Plain bytes read 0, the index is 0, run_en_o is 1 and irq_o is 0.
- R12: Soft reset clears bits 6, 5 and 3 of byte 0x0B and all of byte 0x0C, and lowers irq_o. It clears byte 0x0F unless that byte holds 0xFE. All other bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| srst_n | input | 1 | Synchronous soft reset, active low |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (triggers read-to-clear) |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational from index; 0xFF on the index port |
| tick_i | input | 1 | One pulse per period of the 32.768 kHz time base |
| pf_i | input | 1 | Periodic flag pulse |
| af_i | input | 1 | Alarm flag pulse |
| uf_i | input | 1 | Update-ended flag pulse |
| irq_o | output | 1 | Interrupt line (IRQF) |
| run_en_o | output | 1 | Time counters may advance |
| upd_o | output | 1 | One-second update strobe |

## Verification
Register writes, index loads and flag pulses take effect at the clock edge that ends their bus cycle. Therefore irq_o, run_en_o and every register readback are sampled on the following falling edge. rdata is a combinational function of the index, so a read-to-clear captures its value at the falling edge before the clearing edge. The strobe interval and the width of the update-in-progress window are measured in falling edges, counted from the edge that commits a release or a resume. With tick_i held high, the first strobe after a release is due on count TICKS/2, and every later one on count TICKS.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

    localparam int IDX_W  = 7;
    localparam int BYTE_W = 8;

    localparam logic [IDX_W-1:0] IDX_A    = 7'h0A;
    localparam logic [IDX_W-1:0] IDX_B    = 7'h0B;
    localparam logic [IDX_W-1:0] IDX_C    = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_D    = 7'h0D;
    localparam logic [IDX_W-1:0] IDX_SHUT = 7'h0F;

    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_UIE  = 4;

    localparam logic [6:0]        A_POR       = 7'h26;
    localparam logic [BYTE_W-1:0] B_POR       = 8'h02;
    localparam logic [BYTE_W-1:0] D_CONST     = 8'h80;
    localparam logic [BYTE_W-1:0] SHUT_KEEP   = 8'hFE;
    localparam logic [BYTE_W-1:0] B_SRST_MASK = 8'h68;

    typedef enum logic [1:0] {
        ST_DIVRST,
        ST_IDLE,
        ST_FROZEN,
        ST_RUN
    } div_state_e;

    function automatic div_state_e div_target(input logic [2:0] div, input logic set_bit);
        if (div[2:1] == 2'b11)  return ST_DIVRST;
        else if (div > 3'd2)    return ST_IDLE;
        else if (set_bit)       return ST_FROZEN;
        else                    return ST_RUN;
    endfunction

endpackage

// File: rtl/rtc_div_fsm.sv
module rtc_div_fsm
    import rtc_ctl_pkg::*;
#(
    parameter int TICKS = 32768,
    parameter int UIP_W = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick_i,
    input  logic [2:0] div_nxt,
    input  logic       set_nxt,
    output logic       run_o,
    output logic       uip_o,
    output logic       upd_o
);

    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST     = CW'(TICKS - 1);
    localparam logic [CW-1:0] HALF     = CW'(TICKS / 2);
    localparam logic [CW-1:0] UIP_FROM = CW'(TICKS - UIP_W);
    localparam div_state_e    POR_ST   = div_target(A_POR[6:4], B_POR[B_SET]);

    div_state_e    state_q, state_n, tgt;
    logic [CW-1:0] cnt_q;
    logic          load_half, clr_phase, advance;

    // next-state and phase actions
    always_comb begin
        tgt       = div_target(div_nxt, set_nxt);
        state_n   = tgt;
        load_half = 1'b0;
        clr_phase = 1'b0;
        unique case (state_q)
            ST_DIVRST:                  load_half = (tgt == ST_RUN);
            ST_IDLE, ST_FROZEN, ST_RUN: clr_phase = (tgt == ST_DIVRST);
            default:                    ;
        endcase
        advance = (state_q == ST_RUN) && (tgt == ST_RUN) && tick_i;
    end

    always_ff @(posedge clk) begin
        if (!por_n) state_q <= POR_ST;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!por_n)         cnt_q <= '0;
        else if (clr_phase) cnt_q <= '0;
        else if (load_half) cnt_q <= HALF;
        else if (advance)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_comb begin
        run_o = (state_q == ST_RUN);
        uip_o = run_o && (cnt_q >= UIP_FROM);
        upd_o = advance && (cnt_q == LAST);
    end

    a_r8_strobe_in_uip: assert property (@(posedge clk) disable iff (!por_n)
        upd_o |-> uip_o);
    a_r9_half_after_release: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_RUN && $past(state_q) == ST_DIVRST) |-> cnt_q == HALF);
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_DIVRST) |-> (cnt_q == '0 && !uip_o && !upd_o));
    a_r10_frozen_holds: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_FROZEN && $past(state_q) == ST_FROZEN) |-> $stable(cnt_q));

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_ctl_pkg::*;
#(
    parameter int NF = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              srst_n,
    input  logic [NF-1:0]     set_i,
    input  logic [NF-1:0]     en_i,
    input  logic              rd_clr_i,
    input  logic              b_wr_i,
    input  logic [NF-1:0]     b_en_i,
    output logic [BYTE_W-1:0] c_o,
    output logic              irq_o
);

    localparam int PAD = BYTE_W - 1 - NF;

    logic [NF-1:0] flags_q, base, fresh, flags_n;
    logic          irqf_q, irqf_n;

    always_comb begin
        base    = rd_clr_i ? '0 : flags_q;
        fresh   = set_i & ~base;
        flags_n = base | set_i;
        if (b_wr_i) irqf_n = |(b_en_i & flags_n);
        else        irqf_n = (irqf_q && !rd_clr_i) || |(fresh & en_i);
    end

    always_ff @(posedge clk) begin
        if (!por_n || !srst_n) begin
            flags_q <= '0;
            irqf_q  <= 1'b0;
        end else begin
            flags_q <= flags_n;
            irqf_q  <= irqf_n;
        end
    end

    assign c_o   = {irqf_q, flags_q, {PAD{1'b0}}};
    assign irq_o = irqf_q;

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!por_n)
        (rd_clr_i && set_i == '0) |=> (c_o == '0 && !irq_o));
    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (!rd_clr_i && srst_n) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    a_r5_raise: assert property (@(posedge clk) disable iff (!por_n)
        (!b_wr_i && !rd_clr_i && srst_n && |(set_i & en_i & ~flags_q)) |=> irq_o);
    a_r6_immediate: assert property (@(posedge clk) disable iff (!por_n)
        (b_wr_i && !rd_clr_i && srst_n && |(b_en_i & flags_q)) |=> irq_o);

endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
    import rtc_ctl_pkg::*;
#(
    parameter int TICKS = 32768,
    parameter int UIP_W = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       srst_n,
    input  logic       port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       tick_i,
    input  logic       pf_i,
    input  logic       af_i,
    input  logic       uf_i,
    output logic       irq_o,
    output logic       run_en_o,
    output logic       upd_o
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int NF    = 3;

    logic [IDX_W-1:0]  idx_q;
    logic [6:0]        a_q, a_nxt;
    logic [BYTE_W-1:0] b_q, b_nxt, c_val;
    logic [BYTE_W-1:0] bytes_q [DEPTH];
    logic              wr_idx, wr_dat, rd_dat, hit_a, hit_b, hit_c, uip;

    always_comb begin
        wr_idx = wr_en && !port_sel;
        wr_dat = wr_en && port_sel;
        rd_dat = rd_en && port_sel;
        hit_a  = (idx_q == IDX_A);
        hit_b  = (idx_q == IDX_B);
        hit_c  = (idx_q == IDX_C);
        a_nxt  = (wr_dat && hit_a) ? wdata[6:0] : a_q;
        b_nxt  = ((wr_dat && hit_b) ? wdata : b_q) & (srst_n ? 8'hFF : ~B_SRST_MASK);
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            idx_q <= '0;
            a_q   <= A_POR;
            b_q   <= B_POR;
        end else begin
            if (wr_idx) idx_q <= wdata[IDX_W-1:0];
            a_q <= a_nxt;
            b_q <= b_nxt;
        end
    end

    // plain byte storage; control indices are never written here
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!por_n) begin
                bytes_q[i] <= '0;
            end else if (IDX_W'(i) != IDX_A && IDX_W'(i) != IDX_B &&
                         IDX_W'(i) != IDX_C && IDX_W'(i) != IDX_D) begin
                if (wr_dat && idx_q == IDX_W'(i)) bytes_q[i] <= wdata;
                if (IDX_W'(i) == IDX_SHUT && !srst_n && bytes_q[i] != SHUT_KEEP)
                    bytes_q[i] <= '0;
            end
        end
    end

    rtc_div_fsm #(.TICKS(TICKS), .UIP_W(UIP_W)) u_div (
        .clk     (clk),
        .por_n   (por_n),
        .tick_i  (tick_i),
        .div_nxt (a_nxt[6:4]),
        .set_nxt (b_nxt[B_SET]),
        .run_o   (run_en_o),
        .uip_o   (uip),
        .upd_o   (upd_o)
    );

    rtc_flag_unit #(.NF(NF)) u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .srst_n   (srst_n),
        .set_i    ({pf_i, af_i, uf_i}),
        .en_i     (b_q[B_PIE:B_UIE]),
        .rd_clr_i (rd_dat && hit_c),
        .b_wr_i   (wr_dat && hit_b),
        .b_en_i   (wdata[B_PIE:B_UIE]),
        .c_o      (c_val),
        .irq_o    (irq_o)
    );

    always_comb begin
        if (!port_sel) begin
            rdata = 8'hFF;
        end else begin
            case (idx_q)
                IDX_A:   rdata = {uip, a_q};
                IDX_B:   rdata = b_q;
                IDX_C:   rdata = c_val;
                IDX_D:   rdata = D_CONST;
                default: rdata = bytes_q[idx_q];
            endcase
        end
    end

    a_r1_index_low7: assert property (@(posedge clk) disable iff (!por_n)
        wr_idx |=> idx_q == $past(wdata[IDX_W-1:0]));
    a_r3_uip_stopped: assert property (@(posedge clk) disable iff (!por_n)
        (a_q[6:5] == 2'b11) |-> !uip);
    a_r7_run_gate: assert property (@(posedge clk) disable iff (!por_n)
        run_en_o |-> (!b_q[B_SET] && a_q[6:4] <= 3'd2));
    a_r12_shut_rule: assert property (@(posedge clk) disable iff (!por_n)
        !srst_n |=> (bytes_q[IDX_SHUT] == 8'h00 || bytes_q[IDX_SHUT] == SHUT_KEEP));

endmodule

// File: tb/sim_rtc_index_regs.sv
module sim_rtc_index_regs;

    localparam int TK = 64;
    localparam int UW = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, srst_n = 1'b1;
    logic       port_sel = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tick_i = 1'b1, pf_i = 1'b0, af_i = 1'b0, uf_i = 1'b0;
    logic       irq_o, run_en_o, upd_o;

    always #10 clk = ~clk;

    rtc_index_regs #(.TICKS(TK), .UIP_W(UW)) u0 (
        .clk(clk), .por_n(por_n), .srst_n(srst_n), .port_sel(port_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .tick_i(tick_i), .pf_i(pf_i), .af_i(af_i), .uf_i(uf_i),
        .irq_o(irq_o), .run_en_o(run_en_o), .upd_o(upd_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0] shadow [128];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_idx(input logic [7:0] d);
        @(negedge clk); port_sel = 1'b0; wr_en = 1'b1; wdata = d;
        @(posedge clk); #2 wr_en = 1'b0; port_sel = 1'b1;
    endtask

    task automatic bus_wr(input logic [7:0] d);
        @(negedge clk); port_sel = 1'b1; wr_en = 1'b1; wdata = d;
        @(posedge clk); #2 wr_en = 1'b0;
    endtask

    task automatic bus_rd(output logic [7:0] d);
        @(negedge clk); port_sel = 1'b1; rd_en = 1'b1; #2 d = rdata;
        @(posedge clk); #2 rd_en = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        bus_idx(i); bus_wr(d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
        bus_idx(i); bus_rd(d);
    endtask

    task automatic pulse(input logic [2:0] p);
        @(negedge clk); {pf_i, af_i, uf_i} = p;
        @(posedge clk); #2 {pf_i, af_i, uf_i} = 3'b000;
    endtask

    task automatic soft_reset();
        @(negedge clk); srst_n = 1'b0;
        @(posedge clk); #2 srst_n = 1'b1;
    endtask

    // counts falling edges up to and including the strobe; u counts rdata[7]==1
    task automatic wait_strobe(output int n, output int u, output logic uip_at);
        bit hit = 0;
        n = 0; u = 0; uip_at = 1'b0;
        while (!hit && n < 4 * TK) begin
            @(negedge clk);
            n++;
            if (rdata[7]) u++;
            if (upd_o) begin hit = 1; uip_at = rdata[7]; end
        end
    endtask

    function automatic bit is_ctl(input logic [6:0] a);
        return a >= 7'h0A && a <= 7'h0D;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [2:0] mf, men;
        logic       mirq, uat;
        int         n, u, cnt;

        void'($urandom(32'd5150));
        for (int i = 0; i < 128; i++) shadow[i] = 8'h00;

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R11 power-on state
        check("R11 run_en", {31'd0, run_en_o}, 32'd1);
        check("R11 irq", {31'd0, irq_o}, 32'd0);
        check("R11 index0 byte", {24'd0, rdata}, 32'h00);
        reg_rd(8'h0A, d); check("R11 A", {24'd0, d}, 32'h26);
        reg_rd(8'h0B, d); check("R11 B", {24'd0, d}, 32'h02);
        reg_rd(8'h0C, d); check("R11 C", {24'd0, d}, 32'h00);
        reg_rd(8'h0D, d); check("R11 D", {24'd0, d}, 32'h80);

        // R1 index masking and plain storage
        bus_idx(8'h85); bus_wr(8'hA5); shadow[5] = 8'hA5;
        reg_rd(8'h05, d); check("R1 masked index", {24'd0, d}, 32'hA5);
        for (int k = 0; k < 40; k++) begin
            logic [6:0] a;
            logic [7:0] v, hi;
            a = 7'($urandom);
            while (is_ctl(a)) a = 7'($urandom);
            v = 8'($urandom);
            hi = 8'($urandom) & 8'h80;
            bus_idx(hi | {1'b0, a}); bus_wr(v);
            shadow[a] = v;
        end
        for (int k = 0; k < 30; k++) begin
            logic [6:0] a;
            a = 7'($urandom);
            while (is_ctl(a)) a = 7'($urandom);
            reg_rd({1'b0, a}, d);
            check("R1 readback", {24'd0, d}, {24'd0, shadow[a]});
        end

        // R3 + R9: divider reset, bit 7 not writable
        reg_wr(8'h0A, 8'hE6);
        reg_rd(8'h0A, d); check("R3 A bit7 ignored", {24'd0, d}, 32'h66);
        check("R9 run_en in divider reset", {31'd0, run_en_o}, 32'd0);
        cnt = 0; u = 0;
        for (int k = 0; k < 3 * TK; k++) begin
            @(negedge clk);
            if (upd_o) cnt++;
            if (rdata[7]) u++;
        end
        check("R9 no strobe in reset", cnt, 0);
        check("R9 uip low in reset", u, 0);
        bus_wr(8'h26);
        wait_strobe(n, u, uat);
        check("R9 half second after release", n, TK / 2);
        wait_strobe(n, u, uat);
        check("R8 strobe interval", n, TK);
        check("R8 uip window width", u, UW);
        check("R8 uip at strobe", {31'd0, uat}, 32'd1);
        wait_strobe(n, u, uat);
        check("R8 second interval", n, TK);

        // R10 freeze and resume
        bus_idx(8'h0B);
        wait_strobe(n, u, uat);
        bus_wr(8'h82);
        check("R10 run_en frozen", {31'd0, run_en_o}, 32'd0);
        cnt = 0;
        for (int k = 0; k < 2 * TK; k++) begin
            @(negedge clk);
            if (upd_o) cnt++;
        end
        check("R10 no strobe frozen", cnt, 0);
        reg_rd(8'h0A, d); check("R10 uip low frozen", {31'd0, d[7]}, 32'd0);
        reg_wr(8'h0B, 8'h02);
        wait_strobe(n, u, uat);
        check("R10 resume from held phase", n, TK);

        // R7 run gating by rate field and SET
        reg_wr(8'h0A, 8'h06); check("R7 rate 0", {31'd0, run_en_o}, 32'd1);
        reg_wr(8'h0A, 8'h16); check("R7 rate 1", {31'd0, run_en_o}, 32'd1);
        reg_wr(8'h0A, 8'h36); check("R7 rate 3", {31'd0, run_en_o}, 32'd0);
        reg_wr(8'h0A, 8'h46); check("R7 rate 4", {31'd0, run_en_o}, 32'd0);
        reg_wr(8'h0A, 8'h56); check("R7 rate 5", {31'd0, run_en_o}, 32'd0);
        reg_wr(8'h0A, 8'h26); check("R7 rate 2", {31'd0, run_en_o}, 32'd1);
        reg_wr(8'h0B, 8'h82); check("R7 SET stops", {31'd0, run_en_o}, 32'd0);
        reg_wr(8'h0B, 8'h02); check("R7 SET clear", {31'd0, run_en_o}, 32'd1);

        // R4/R5/R6 random flag traffic against a model
        reg_rd(8'h0C, d);
        mf = 3'b000; men = 3'b000; mirq = 1'b0;
        for (int k = 0; k < 150; k++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                logic [2:0] p, nw;
                p = 3'($urandom);
                pulse(p);
                nw = p & ~mf; mf = mf | p;
                if ((nw & men) != 3'b000) mirq = 1'b1;
                @(negedge clk); check("R5 irq after flag", {31'd0, irq_o}, {31'd0, mirq});
            end else if (op == 1) begin
                logic [2:0] e;
                e = 3'($urandom);
                reg_wr(8'h0B, {1'b0, e, 4'b0010});
                men = e; mirq = |(e & mf);
                @(negedge clk); check("R6 irq after enable write", {31'd0, irq_o}, {31'd0, mirq});
            end else begin
                reg_rd(8'h0C, d);
                check("R4 flag byte", {24'd0, d}, {24'd0, mirq, mf, 4'b0000});
                mf = 3'b000; mirq = 1'b0;
                @(negedge clk); check("R4 irq after read", {31'd0, irq_o}, 32'd0);
            end
        end

        // R4 same-cycle set survives the clear
        reg_wr(8'h0B, 8'h42);
        reg_rd(8'h0C, d);
        @(negedge clk); rd_en = 1'b1; pf_i = 1'b1; #2 d = rdata;
        @(posedge clk); #2 rd_en = 1'b0; pf_i = 1'b0;
        check("R4 read before set", {24'd0, d}, 32'h00);
        @(negedge clk); check("R4 set survives irq", {31'd0, irq_o}, 32'd1);
        reg_rd(8'h0C, d); check("R4 set survives flag", {24'd0, d}, 32'hC0);

        // R2 read-only bytes
        reg_wr(8'h0C, 8'hFF);
        @(negedge clk); check("R2 C write no irq", {31'd0, irq_o}, 32'd0);
        reg_rd(8'h0C, d); check("R2 C write ignored", {24'd0, d}, 32'h00);
        reg_wr(8'h0D, 8'h00);
        reg_rd(8'h0D, d); check("R2 D constant", {24'd0, d}, 32'h80);

        // R12 soft reset
        reg_wr(8'h0B, 8'h7E);
        pulse(3'b111);
        @(negedge clk); check("R12 irq before", {31'd0, irq_o}, 32'd1);
        reg_wr(8'h0F, 8'hFE);
        reg_wr(8'h20, 8'h5A);
        soft_reset();
        @(negedge clk); check("R12 irq low", {31'd0, irq_o}, 32'd0);
        reg_rd(8'h0B, d); check("R12 B enables cleared", {24'd0, d}, 32'h16);
        reg_rd(8'h0C, d); check("R12 C cleared", {24'd0, d}, 32'h00);
        reg_rd(8'h0F, d); check("R12 0x0F keeps FE", {24'd0, d}, 32'hFE);
        reg_rd(8'h20, d); check("R12 other byte kept", {24'd0, d}, 32'h5A);
        reg_wr(8'h0F, 8'h33);
        soft_reset();
        reg_rd(8'h0F, d); check("R12 0x0F cleared", {24'd0, d}, 32'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule